// File: doc/BRIEF.md
# Falling-Edge DMA Request Acceptor

This block sits between an active-low DMA request pin and the channel sequencer of one DMA channel working in single-address mode. It turns each falling edge on the pin into exactly one held transfer request. After an enabling control write, the block opens acceptance and samples the synchronised pin on every clock. A low level then latches a pending request for the arbiter. When the sequencer starts activation, the pending request is dropped and the block watches for the pin to go high again. Acceptance reopens only after the current single transfer cycle has finished and a high level has been seen. A held-low pin therefore cannot produce a second request.

A small timing stub inside the block stands in for the bus side of one single cycle. After activation it waits out a bus-release period and then raises the acknowledge for a fixed number of cycles. This lets the whole request, activation, transfer and resume loop run without a real bus. A transfer-end strobe or a disabling control write returns the block to idle. It stays idle until the next enabling write.

Top module: `dreq_edge_acceptor`

## Requirements
- R1: After reset, req_pending, accept_open, xfer_ack and cyc_done are all 0.
- R2: A cycle with ctl_wr=1, ctl_en=1 and pin_sel=1 sets accept_open to 1 from the next cycle. With pin_sel=0, the same write leaves the block idle with accept_open=0.
- R3: The pin goes through a two-stage synchroniser. If dreq_n is low at clock edge k while accept_open=1, req_pending is 1 after edge k+2 and accept_open drops to 0 at the same time.
- R4: req_pending stays 1 until act_start is sampled high. act_start has no effect while req_pending=0.
- R5: act_start sampled with req_pending=1 clears req_pending at that edge. xfer_ack is then 1 for SGL_CYC cycles, starting REL_CYC cycles after activation. cyc_done is 1 in the last cycle of xfer_ack.
- R6: If the synchronised pin was high at any edge from activation up to the cyc_done edge, accept_open becomes 1 right after that cyc_done edge.
- R7: If no high level was seen by the cyc_done edge, accept_open stays 0. It becomes 1 one edge after the synchronised pin is first sampled high.
- R8: xfer_end=1, or a write with ctl_wr=1 and ctl_en=0, forces all four outputs to 0 at the next edge. This ends any single cycle in progress. Pin activity is then ignored until the next enabling write.
- R9: At least two cycles lie between the cycle in which req_pending is 1 and the first cycle of xfer_ack (REL_CYC >= 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dreq_n | input | 1 | Active-low request pin, asynchronous |
| ctl_wr | input | 1 | One-cycle control-register write strobe |
| ctl_en | input | 1 | Enable value carried by the write |
| pin_sel | input | 1 | 1 selects the pin as activation source |
| act_start | input | 1 | Sequencer begins activation of the held request |
| xfer_end | input | 1 | Channel transfer has ended |
| req_pending | output | 1 | Held request toward the arbiter |
| accept_open | output | 1 | Pin low level is currently accepted |
| xfer_ack | output | 1 | Acknowledge during the single cycle |
| cyc_done | output | 1 | Last cycle of the single cycle |

## Verification
An internal state held one edge too long or too short shows up at the ports within one clock. The faulty state moves req_pending, accept_open or xfer_ack out of step with the model, and the bench compares those every cycle. The bench mostly catches a lost or stale high-level flag when the pin stays low through a single cycle. In that case a wrong flag reopens acceptance early and yields a second request from one edge, within a few cycles of cyc_done. A synchroniser depth error shifts the first req_pending by one cycle.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_OPEN   = 3'd1,
        ST_HELD   = 3'd2,
        ST_XFER   = 3'd3,
        ST_WAITHI = 3'd4
    } acc_state_e;

    typedef struct packed {
        logic en_wr;
        logic stop;
    } ctl_evt_t;

    function automatic ctl_evt_t decode_ctl(input logic wr, input logic en,
                                            input logic sel, input logic xend);
        ctl_evt_t e;
        e.en_wr = wr & en & sel;
        e.stop  = xend | (wr & ~en);
        return e;
    endfunction

endpackage

// File: rtl/dreq_sync.sv
module dreq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '1;
        else     sh <= {sh[STAGES-2:0], d};
    end

    assign q = sh[STAGES-1];
endmodule

// File: rtl/dreq_xfer_stub.sv
module dreq_xfer_stub #(
    parameter int REL_CYC = 2,
    parameter int SGL_CYC = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic abort,
    output logic ack,
    output logic done
);
    localparam int TOT = REL_CYC + SGL_CYC;
    localparam int CW  = $clog2(TOT + 1);
    localparam logic [CW-1:0] REL_V  = CW'(REL_CYC);
    localparam logic [CW-1:0] LAST_V = CW'(TOT - 1);

    logic          busy;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (busy) begin
            if (cnt == LAST_V) begin
                busy <= 1'b0;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign ack  = busy && (cnt >= REL_V);
    assign done = busy && (cnt == LAST_V);
endmodule

// File: rtl/dreq_accept_fsm.sv
module dreq_accept_fsm
    import dma_req_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     pin_s,
    input  ctl_evt_t evt,
    input  logic     act_start,
    input  logic     stub_done,
    output logic     act_go,
    output logic     pending,
    output logic     open_o
);
    acc_state_e st, st_nx;
    logic       hi_seen, hi_nx;

    assign act_go = (st == ST_HELD) && act_start && !evt.stop;

    always_comb begin
        st_nx = st;
        hi_nx = hi_seen;
        if (evt.stop) begin
            st_nx = ST_IDLE;
            hi_nx = 1'b0;
        end else begin
            unique case (st)
                ST_IDLE:   if (evt.en_wr) st_nx = ST_OPEN;
                ST_OPEN:   if (!pin_s)    st_nx = ST_HELD;
                ST_HELD:   if (act_start) begin
                               st_nx = ST_XFER;
                               hi_nx = 1'b0;
                           end
                ST_XFER:   begin
                               if (stub_done) begin
                                   st_nx = (hi_seen || pin_s) ? ST_OPEN : ST_WAITHI;
                                   hi_nx = 1'b0;
                               end else begin
                                   hi_nx = hi_seen | pin_s;
                               end
                           end
                ST_WAITHI: if (pin_s) st_nx = ST_OPEN;
                default:   st_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            hi_seen <= 1'b0;
        end else begin
            st      <= st_nx;
            hi_seen <= hi_nx;
        end
    end

    assign pending = (st == ST_HELD);
    assign open_o  = (st == ST_OPEN);
endmodule

// File: rtl/dreq_edge_acceptor.sv
module dreq_edge_acceptor
    import dma_req_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int REL_CYC     = 2,
    parameter int SGL_CYC     = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic dreq_n,
    input  logic ctl_wr,
    input  logic ctl_en,
    input  logic pin_sel,
    input  logic act_start,
    input  logic xfer_end,
    output logic req_pending,
    output logic accept_open,
    output logic xfer_ack,
    output logic cyc_done
);
    logic     pin_s;
    logic     act_go;
    ctl_evt_t evt;

    assign evt = decode_ctl(ctl_wr, ctl_en, pin_sel, xfer_end);

    dreq_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .d(dreq_n), .q(pin_s)
    );

    dreq_accept_fsm fsm_i (
        .clk(clk), .rst(rst), .pin_s(pin_s), .evt(evt),
        .act_start(act_start), .stub_done(cyc_done),
        .act_go(act_go), .pending(req_pending), .open_o(accept_open)
    );

    dreq_xfer_stub #(.REL_CYC(REL_CYC), .SGL_CYC(SGL_CYC)) stub_i (
        .clk(clk), .rst(rst), .start(act_go), .abort(evt.stop),
        .ack(xfer_ack), .done(cyc_done)
    );
endmodule

// File: rtl/dreq_edge_acceptor_chk.sv
module dreq_edge_acceptor_chk (
    input logic clk,
    input logic rst,
    input logic ctl_wr,
    input logic ctl_en,
    input logic act_start,
    input logic xfer_end,
    input logic req_pending,
    input logic accept_open,
    input logic xfer_ack,
    input logic cyc_done
);
    // R4
    held_until_act_chk: assert property (@(posedge clk) disable iff (rst)
        (req_pending && !act_start && !xfer_end && !(ctl_wr && !ctl_en)) |=> req_pending);

    // R3
    pend_from_open_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(req_pending) |-> $past(accept_open));

    // R5
    ack_ends_chk: assert property (@(posedge clk) disable iff (rst)
        cyc_done |=> !xfer_ack);

    // R8
    stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_end |=> (!req_pending && !accept_open && !xfer_ack && !cyc_done));

    // R9
    release_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(xfer_ack) |-> !$past(req_pending));

    // R5
    no_ack_while_pend_chk: assert property (@(posedge clk) disable iff (rst)
        !(req_pending && xfer_ack));
endmodule

bind dreq_edge_acceptor dreq_edge_acceptor_chk chk_i (.*);

// File: tb/dreq_edge_acceptor_tb_top.sv
`timescale 1ns/1ps
module dreq_edge_acceptor_tb_top;
    localparam int REL = 2;
    localparam int SGL = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dreq_n = 1'b1, ctl_wr = 1'b0, ctl_en = 1'b0, pin_sel = 1'b0;
    logic act_start = 1'b0, xfer_end = 1'b0;
    logic req_pending, accept_open, xfer_ack, cyc_done;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    string tag = "R1";

    always #2.5 clk = ~clk;

    dreq_edge_acceptor #(.SYNC_STAGES(2), .REL_CYC(REL), .SGL_CYC(SGL)) dut_i (
        .clk(clk), .rst(rst), .dreq_n(dreq_n), .ctl_wr(ctl_wr), .ctl_en(ctl_en),
        .pin_sel(pin_sel), .act_start(act_start), .xfer_end(xfer_end),
        .req_pending(req_pending), .accept_open(accept_open),
        .xfer_ack(xfer_ack), .cyc_done(cyc_done)
    );

    // behavioural reference: 0 idle, 1 open, 2 held, 3 transfer, 4 wait-high
    int m_st = 0, m_cnt = 0;
    bit m_busy = 0, m_hi = 0, m_s1 = 1, m_s2 = 1;

    always @(posedge clk) begin
        bit s2_old, done_old;
        s2_old   = m_s2;
        done_old = m_busy && (m_cnt == REL + SGL - 1);
        if (rst) begin
            m_st = 0; m_busy = 0; m_cnt = 0; m_hi = 0; m_s1 = 1; m_s2 = 1;
        end else begin
            if (xfer_end || (ctl_wr && !ctl_en)) begin
                m_st = 0; m_busy = 0; m_cnt = 0; m_hi = 0;
            end else begin
                case (m_st)
                    0: if (ctl_wr && ctl_en && pin_sel) m_st = 1;
                    1: if (!s2_old) m_st = 2;
                    2: if (act_start) begin m_st = 3; m_busy = 1; m_cnt = 0; m_hi = 0; end
                    3: if (done_old) begin
                           m_st = (m_hi || s2_old) ? 1 : 4;
                           m_busy = 0; m_cnt = 0; m_hi = 0;
                       end else begin
                           m_cnt++; m_hi = m_hi | s2_old;
                       end
                    4: if (s2_old) m_st = 1;
                    default: m_st = 0;
                endcase
            end
            m_s2 = m_s1;
            m_s1 = dreq_n;
        end
    end

    always @(negedge clk) begin
        bit e_p, e_o, e_a, e_d;
        if (!finished) begin
            e_p = (m_st == 2);
            e_o = (m_st == 1);
            e_a = m_busy && (m_cnt >= REL);
            e_d = m_busy && (m_cnt == REL + SGL - 1);
            checks++;
            if ({req_pending, accept_open, xfer_ack, cyc_done} !== {e_p, e_o, e_a, e_d}) begin
                failures++;
                $display("FAIL %s t=%0t pend/open/ack/done actual=%b%b%b%b expected=%b%b%b%b",
                         tag, $time, req_pending, accept_open, xfer_ack, cyc_done,
                         e_p, e_o, e_a, e_d);
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_wr(input bit en, input bit sel);
        ctl_wr = 1; ctl_en = en; pin_sel = sel;
        cyc(1);
        ctl_wr = 0;
    endtask

    task automatic pulse_act();
        act_start = 1; cyc(1); act_start = 0;
    endtask

    task automatic finish_run();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #50000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired in phase %s", tag);
            finish_run();
        end
    end

    initial begin
        @(negedge clk);
        tag = "R1"; cyc(3); rst = 0; cyc(2);
        tag = "R2"; pulse_wr(1, 0); cyc(4);
        pulse_wr(1, 1); cyc(2);
        tag = "R3"; dreq_n = 0; cyc(4);
        tag = "R4"; cyc(3);
        tag = "R5 R9"; pulse_act();
        tag = "R6"; dreq_n = 1; cyc(8);
        tag = "R7"; dreq_n = 0; cyc(4); pulse_act(); cyc(10);
        dreq_n = 1; cyc(4);
        tag = "R4"; pulse_act(); cyc(3);
        tag = "R8"; dreq_n = 0; cyc(4); pulse_act(); cyc(3);
        xfer_end = 1; cyc(1); xfer_end = 0; cyc(3);
        dreq_n = 1; cyc(3); dreq_n = 0; cyc(4);
        pulse_wr(1, 1); cyc(4); pulse_act(); cyc(2);
        pulse_wr(0, 1); cyc(5);
        tag = "R6"; dreq_n = 1; pulse_wr(1, 1); cyc(3);
        dreq_n = 0; cyc(1); dreq_n = 1; cyc(4); pulse_act(); cyc(8);
        finish_run();
    end
endmodule